// File: doc/BRIEF.md
# Queued Asynchronous Serial Transmitter

This block turns parallel words into asynchronous serial frames on a single line that idles high. Words come in through a one-cycle write strobe and wait in a queue of up to 16 entries. The shifter takes them in the order they were written. A baud tick from an external rate generator paces every bit period. The word length, parity and stop count are configurable.

In queued mode the shifter reads its next word straight from the queue. It can hold the line idle for a programmable number of bit periods between back-to-back frames. The interrupt output is high while the queue occupancy equals a programmable trigger level, so a level of zero signals that the queue has fully drained. In single-word mode the same storage shrinks to one holding slot, the idle gap is not applied, and the interrupt means the slot is free for the next word. A transmit enable gates the start of new frames only. A frame already on the line always finishes.

Top module: `uart_fifo_tx`

## Requirements
- R1: Each frame begins with one low start bit, followed by `word_len`+1 data bits (`word_len` is 3 bits, 0 means 1 bit and 7 means 8 bits), least significant bit first; the line is high whenever no frame is being sent.
- R2: With `par_en` high, one parity bit follows the data: with `par_odd` low it equals the XOR of the data bits sent, with `par_odd` high its inverse; with `par_en` low no parity bit is sent.
- R3: The frame ends with one high stop bit when `two_stop` is 0 and two high stop bits when it is 1.
- R4: In queued mode (`fifo_en` high) up to 16 words are stored, are sent in write order, and `fill_cnt` reports the number of stored words.
- R5: A write while the storage is full is dropped without changing the stored words, and sets `ovf` high until reset.
- R6: In queued mode `irq` is high exactly when `fill_cnt` equals `trig_lvl`; with `trig_lvl` 0 it is high only once every queued word has been taken by the shifter.
- R7: In queued mode, `gap_len`=N inserts exactly N idle high bit periods between the last stop bit of one frame and the start bit of the next queued frame; N=0 gives back-to-back frames.
- R8: In single-word mode (`fifo_en` low) the storage holds one word, a second write while it is occupied is dropped, `irq` is high exactly when the slot is empty, and `gap_len` has no effect.
- R9: While `tx_en` is low no new frame starts; a frame already started when `tx_en` falls completes in full.
- R10: After reset the line is high, `fill_cnt` is 0 and `ovf` is 0; the line changes only in a cycle where `baud_tick` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | 8 | Word to queue |
| baud_tick | input | 1 | One-cycle pulse marking a bit-period boundary |
| tx_en | input | 1 | Allows new frames to start |
| fifo_en | input | 1 | 1: 16-word queue, 0: single holding slot |
| word_len | input | 3 | Data bits minus one |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when set, even otherwise |
| two_stop | input | 1 | Two stop bits when set |
| gap_len | input | DLY_W | Idle bit periods between queued frames |
| trig_lvl | input | CW | Interrupt fill level |
| tx_line | output | 1 | Serial output |
| fill_cnt | output | CW | Stored word count |
| irq | output | 1 | Interrupt request |
| ovf | output | 1 | Sticky dropped-write flag |

## Verification
The assertions check the cycle-local properties on every cycle: the idle line is high, the start bit is low and the stop bits are high, the line holds between baud ticks, the occupancy stays within bounds, and a disabled idle shifter stays idle. They also check that writes into full storage are dropped and flagged, and that the flag stays set. Whole-frame properties span many bit periods, so only the bench scenarios can show them. These are bit order, parity value, exact gap length, write-order delivery, the trigger-level timing of `irq`, completion of a frame interrupted by `tx_en`, and `gap_len` being ignored in single-word mode. The bench decodes the recorded line against frames it builds itself.

// File: rtl/uart_fifo_tx.sv
module uart_fifo_tx #(
  parameter int DEPTH = 16,
  parameter int DLY_W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             baud_tick,
  input  logic             tx_en,
  input  logic             fifo_en,
  input  logic [2:0]       word_len,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             two_stop,
  input  logic [DLY_W-1:0] gap_len,
  input  logic [CW-1:0]    trig_lvl,
  output logic             tx_line,
  output logic [CW-1:0]    fill_cnt,
  output logic             irq,
  output logic             ovf
);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2} st_t;

  logic [7:0]       mem [DEPTH];
  logic [AW-1:0]    rd_ptr, wr_ptr;
  logic [CW-1:0]    cnt;
  st_t              st;
  logic [7:0]       sh;
  logic [2:0]       idx;
  logic             pacc;
  logic             txd;
  logic [DLY_W-1:0] gap_cnt;

  wire [CW-1:0]    cap       = fifo_en ? CW'(DEPTH) : CW'(1);
  wire             full      = cnt >= cap;
  wire             push      = wr_en && !full;
  wire             can_start = tx_en && (cnt != '0);
  wire [DLY_W-1:0] gap_eff   = fifo_en ? gap_len : '0;
  wire             frame_end = baud_tick && ((st == S_STOP1 && !two_stop) || st == S_STOP2);
  wire             start_now = baud_tick && can_start &&
                               ((st == S_IDLE && gap_cnt <= DLY_W'(1)) ||
                                (frame_end && gap_eff == '0));
  wire             pop       = start_now;

  function automatic logic [AW-1:0] inc_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      ovf    <= 1'b0;
    end else begin
      if (push) wr_ptr <= inc_ptr(wr_ptr);
      if (pop)  rd_ptr <= inc_ptr(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
      if (wr_en && full) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      txd     <= 1'b1;
      sh      <= '0;
      idx     <= '0;
      pacc    <= 1'b0;
      gap_cnt <= '0;
    end else if (start_now) begin
      st      <= S_START;
      txd     <= 1'b0;
      sh      <= mem[rd_ptr];
      gap_cnt <= '0;
    end else if (baud_tick) begin
      case (st)
        S_IDLE: begin
          txd <= 1'b1;
          if (gap_cnt > DLY_W'(1)) gap_cnt <= gap_cnt - DLY_W'(1);
          else                     gap_cnt <= '0;
        end
        S_START: begin
          txd  <= sh[0];
          pacc <= sh[0];
          sh   <= sh >> 1;
          idx  <= '0;
          st   <= S_DATA;
        end
        S_DATA: begin
          if (idx == word_len) begin
            if (par_en) begin
              txd <= pacc ^ par_odd;
              st  <= S_PAR;
            end else begin
              txd <= 1'b1;
              st  <= S_STOP1;
            end
          end else begin
            txd  <= sh[0];
            pacc <= pacc ^ sh[0];
            sh   <= sh >> 1;
            idx  <= idx + 3'd1;
          end
        end
        S_PAR: begin
          txd <= 1'b1;
          st  <= S_STOP1;
        end
        S_STOP1: begin
          if (two_stop) st <= S_STOP2;
          else begin
            st      <= S_IDLE;
            gap_cnt <= gap_eff;
          end
        end
        default: begin
          st      <= S_IDLE;
          gap_cnt <= gap_eff;
        end
      endcase
    end
  end

  assign tx_line  = txd;
  assign fill_cnt = cnt;
  assign irq      = fifo_en ? (cnt == trig_lvl) : (cnt == '0);

  assert_line_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> tx_line);
  assert_start_bit_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_START |-> !tx_line);
  assert_stop_bits_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP1 || st == S_STOP2) |-> tx_line);
  assert_fill_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CW'(DEPTH));
  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  assert_full_write_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> ovf);
  assert_full_write_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !pop) |=> fill_cnt == $past(fill_cnt));
  assert_single_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && fill_cnt <= CW'(1)) |=> (fifo_en || fill_cnt <= CW'(1)));
  assert_no_start_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && st == S_IDLE) |=> st == S_IDLE);
  assert_line_moves_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(tx_line));

endmodule

// File: tb/test_uart_fifo_tx.sv
`timescale 1ns/1ps
module test_uart_fifo_tx;
  localparam int DEPTH = 16;
  localparam int DLY_W = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [7:0]       wr_data = '0;
  logic             baud_tick = 1'b0;
  logic             tx_en = 1'b0;
  logic             fifo_en = 1'b1;
  logic [2:0]       word_len = 3'd7;
  logic             par_en = 1'b0;
  logic             par_odd = 1'b0;
  logic             two_stop = 1'b0;
  logic [DLY_W-1:0] gap_len = '0;
  logic [CW-1:0]    trig_lvl = '0;
  logic             tx_line;
  logic [CW-1:0]    fill_cnt;
  logic             irq;
  logic             ovf;

  uart_fifo_tx #(.DEPTH(DEPTH), .DLY_W(DLY_W)) i_uart_fifo_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .baud_tick(baud_tick), .tx_en(tx_en), .fifo_en(fifo_en),
    .word_len(word_len), .par_en(par_en), .par_odd(par_odd),
    .two_stop(two_stop), .gap_len(gap_len), .trig_lvl(trig_lvl),
    .tx_line(tx_line), .fill_cnt(fill_cnt), .irq(irq), .ovf(ovf)
  );

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int tdiv = 0;
  bit rec_on = 0;
  bit rec[$];
  bit exp_q[$];

  always @(negedge clk) begin
    if (rec_on && baud_tick) rec.push_back(tx_line);
    tdiv = (tdiv + 1) % 4;
    baud_tick = (tdiv == 0);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic push_frame(input logic [7:0] d, input int wl, input bit pe,
                            input bit po, input bit ts, input int gap);
    bit p = 0;
    exp_q.push_back(1'b0);
    for (int i = 0; i <= wl; i++) begin
      exp_q.push_back(d[i]);
      p ^= d[i];
    end
    if (pe) exp_q.push_back(p ^ po);
    exp_q.push_back(1'b1);
    if (ts) exp_q.push_back(1'b1);
    for (int i = 0; i < gap; i++) exp_q.push_back(1'b1);
  endtask

  task automatic compare_stream(input string req);
    int first = -1;
    int mism = 0;
    int extra = 0;
    for (int i = 0; i < rec.size(); i++)
      if (first < 0 && rec[i] == 1'b0) first = i;
    if (first < 0) begin
      check({req, " start found"}, 0, 1);
      return;
    end
    for (int i = 0; i < exp_q.size(); i++) begin
      if (first + i >= rec.size()) mism++;
      else if (rec[first + i] != exp_q[i]) mism++;
    end
    for (int i = first + exp_q.size(); i < rec.size(); i++)
      if (rec[i] == 1'b0) extra++;
    check({req, " frame bits"}, mism, 0);
    check({req, " idle after"}, extra, 0);
  endtask

  task automatic write_word(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic drain();
    while (fill_cnt != '0) @(negedge clk);
    repeat (120) @(negedge clk);
  endtask

  task automatic run_fifo(input int n, input int wl, input bit pe, input bit po,
                          input bit ts, input int gap);
    int stored;
    tx_en = 1'b0;
    fifo_en = 1'b1;
    word_len = 3'(wl);
    par_en = pe;
    par_odd = po;
    two_stop = ts;
    gap_len = DLY_W'(gap);
    rec.delete();
    exp_q.delete();
    stored = (n > DEPTH) ? DEPTH : n;
    for (int k = 0; k < n; k++) begin
      logic [7:0] d = 8'($urandom);
      write_word(d);
      if (k < DEPTH) push_frame(d, wl, pe, po, ts, (k < stored - 1) ? gap : 0);
    end
    @(negedge clk);
    check("R4 fill count after writes", int'(fill_cnt), stored);
    trig_lvl = CW'(stored);
    @(negedge clk);
    check("R6 irq at matching level", int'(irq), 1);
    trig_lvl = '0;
    @(negedge clk);
    check("R6 irq low while words queued", int'(irq), 0);
    repeat (40) @(negedge clk);
    check("R9 no frame while disabled (line)", int'(tx_line), 1);
    check("R9 no frame while disabled (fill)", int'(fill_cnt), stored);
    rec_on = 1;
    tx_en = 1'b1;
    drain();
    rec_on = 0;
    tx_en = 1'b0;
    compare_stream("R1 R2 R3 R4 R7 stream");
    check("R6 irq after drain at level 0", int'(irq), 1);
  endtask

  initial begin
    void'($urandom(32'h5eed_0017));
    do_reset();
    check("R10 reset line", int'(tx_line), 1);
    check("R10 reset fill", int'(fill_cnt), 0);
    check("R10 reset ovf", int'(ovf), 0);
    check("R6 reset irq level 0", int'(irq), 1);

    run_fifo(3, 7, 0, 0, 0, 0);
    run_fifo(4, 7, 1, 1, 1, 3);
    run_fifo(5, 0, 1, 0, 0, 1);
    run_fifo(2, 4, 1, 0, 1, 2);
    for (int it = 0; it < 6; it++)
      run_fifo(1 + int'($urandom % 16), int'($urandom % 8), 1'($urandom),
               1'($urandom), 1'($urandom), int'($urandom % 4));

    // R6: interrupt tracks the trigger level while draining
    fifo_en = 1'b1; word_len = 3'd7; par_en = 0; two_stop = 0; gap_len = '0;
    trig_lvl = CW'(2);
    for (int k = 0; k < 4; k++) write_word(8'(k + 8'h30));
    tx_en = 1'b1;
    while (fill_cnt != CW'(3)) @(negedge clk);
    check("R6 irq low at fill 3 with level 2", int'(irq), 0);
    while (fill_cnt != CW'(2)) @(negedge clk);
    check("R6 irq high at fill 2 with level 2", int'(irq), 1);
    drain();
    tx_en = 1'b0;
    trig_lvl = '0;

    // R9: enable dropped mid-frame
    rec.delete(); exp_q.delete();
    write_word(8'hA5);
    write_word(8'h3C);
    push_frame(8'hA5, 7, 0, 0, 0, 0);
    rec_on = 1;
    tx_en = 1'b1;
    while (tx_line != 1'b0) @(negedge clk);
    tx_en = 1'b0;
    repeat (200) @(negedge clk);
    rec_on = 0;
    compare_stream("R9 frame completes after disable");
    check("R9 second word held", int'(fill_cnt), 1);
    tx_en = 1'b1;
    drain();
    tx_en = 1'b0;
    check("R9 second word sent after re-enable", int'(fill_cnt), 0);

    // R5: overflow of the 16-word queue
    do_reset();
    check("R5 ovf clear after reset", int'(ovf), 0);
    run_fifo(17, 7, 0, 0, 0, 0);
    check("R5 ovf set by dropped write", int'(ovf), 1);

    // R8: single-word mode
    do_reset();
    fifo_en = 1'b0; word_len = 3'd7; par_en = 1; par_odd = 0; two_stop = 0;
    gap_len = DLY_W'(3);
    tx_en = 1'b0;
    rec.delete(); exp_q.delete();
    check("R8 irq with empty slot", int'(irq), 1);
    write_word(8'h5A);
    check("R8 fill after first write", int'(fill_cnt), 1);
    check("R8 irq low with slot occupied", int'(irq), 0);
    write_word(8'hFF);
    check("R8 second write dropped", int'(fill_cnt), 1);
    check("R5 ovf in single-word mode", int'(ovf), 1);
    push_frame(8'h5A, 7, 1, 0, 0, 0);
    push_frame(8'hC3, 7, 1, 0, 0, 0);
    rec_on = 1;
    tx_en = 1'b1;
    while (fill_cnt != '0) @(negedge clk);
    check("R8 irq once slot moves to shifter", int'(irq), 1);
    write_word(8'hC3);
    check("R8 refill while shifting", int'(fill_cnt), 1);
    drain();
    rec_on = 0;
    tx_en = 1'b0;
    compare_stream("R8 back-to-back, gap ignored");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule